// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the raster timing for a parallel RGB TFT panel. It keeps a horizontal pixel counter and a vertical line counter. From these counters it drives horizontal sync, vertical sync and a data-enable window, and it reports the current X/Y position together with an active-pixel strobe. A downstream pixel fetch stage uses that strobe and position. Every frame runs through four phases on each axis in a fixed order: sync, back porch, active area, front porch.

Each axis is set up by four cumulative boundary positions rather than four widths:

- sync end = sync width − 1
- back-porch end = sync + back porch − 1
- active end = sync + back porch + active − 1
- total = sync + back porch + active + front porch − 1

Example: a 320x240 panel with horizontal sync/back porch/front porch of 10/20/10 pixels and vertical sync/back porch/front porch of 2/2/4 lines uses these boundaries:

- horizontal: 9, 29, 349, 359
- vertical: 1, 3, 243, 247

Each of HSYNC, VSYNC and DE has its own polarity select. While the block is disabled, both counters rest on the last pixel before vertical sync and only blanking is driven.

Top module: `disp_raster_gen`

## Requirements
- R1: While reset is asserted or `enable` is low, X sits at `h_total` and Y at `v_total` from the next clock edge on.
- R2: While the generator is not running (reset, or `enable` low at the last edge), HSYNC, VSYNC and DE sit at their inactive levels and `pix_valid` is 0.
- R3: On the first clock edge that samples `enable` high, the position becomes X=0, Y=0. HSYNC and VSYNC are both active there.
- R4: While running, X advances by one per clock. After X reaches `h_total`, it returns to 0 and Y advances by one. After Y reaches `v_total` on that wrap, Y returns to 0. Y holds at all other times.
- R5: While running, HSYNC is active exactly when X ≤ `h_sync_end`.
- R6: While running, VSYNC is active exactly when Y ≤ `v_sync_end`.
- R7: DE is active exactly when `h_bp_end` < X ≤ `h_act_end` and `v_bp_end` < Y ≤ `v_act_end` both hold. For the 320x240 example, DE first rises 4·360+30 clocks after the enabling edge, and it is active for 76800 clocks per frame.
- R8: A polarity select of 1 makes the matching output active high. A select of 0 makes it active low. The selects are `pol_hsync`, `pol_vsync` and `pol_de`.
- R9: `pix_valid` is active high regardless of `pol_de`, and it is high exactly when DE is active.
- R10: Dropping `enable` in mid-frame parks the counters on the next edge. Raising it again restarts the frame at X=0, Y=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the raster when high; park when low |
| h_sync_end | input | 12 | Last X of horizontal sync |
| h_bp_end | input | 12 | Last X of horizontal back porch |
| h_act_end | input | 12 | Last X of active width |
| h_total | input | 12 | Last X of the line |
| v_sync_end | input | 11 | Last Y of vertical sync |
| v_bp_end | input | 11 | Last Y of vertical back porch |
| v_act_end | input | 11 | Last Y of active height |
| v_total | input | 11 | Last Y of the frame |
| pol_hsync | input | 1 | 1: HSYNC active high |
| pol_vsync | input | 1 | 1: VSYNC active high |
| pol_de | input | 1 | 1: DE active high |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pos_x | output | 12 | Current X position |
| pos_y | output | 11 | Current Y position |
| pix_valid | output | 1 | Active-pixel strobe, active high |

## Verification
The hardest case to reach is the frame wrap, where X and Y both sit at their totals. It comes only after a full frame of pixels, 89280 clocks for the 320x240 example. It is also the point where the parked state meets the running state. The stimulus runs the example geometry for two complete frames without a break, so the wrap from the last pixel back to the origin is crossed twice. A short custom geometry then disables the generator in mid-frame and re-enables it, which forces the parked-to-origin step away from a natural wrap.

// File: rtl/disp_raster_gen.sv
module disp_raster_gen #(
  parameter int XW = 12,
  parameter int YW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [XW-1:0] h_sync_end,
  input  logic [XW-1:0] h_bp_end,
  input  logic [XW-1:0] h_act_end,
  input  logic [XW-1:0] h_total,
  input  logic [YW-1:0] v_sync_end,
  input  logic [YW-1:0] v_bp_end,
  input  logic [YW-1:0] v_act_end,
  input  logic [YW-1:0] v_total,
  input  logic          pol_hsync,
  input  logic          pol_vsync,
  input  logic          pol_de,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y,
  output logic          pix_valid
);

  logic          run_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic          x_last, y_last;
  logic          hs_act, vs_act, de_act;

  assign x_last = (x_q >= h_total);
  assign y_last = (y_q >= v_total);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      x_q   <= h_total;
      y_q   <= v_total;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (x_last) begin
        x_q <= '0;
        y_q <= y_last ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assign hs_act = run_q && (x_q <= h_sync_end);
  assign vs_act = run_q && (y_q <= v_sync_end);
  assign de_act = run_q && (x_q > h_bp_end) && (x_q <= h_act_end)
                        && (y_q > v_bp_end) && (y_q <= v_act_end);

  assign hsync     = pol_hsync ? hs_act : ~hs_act;
  assign vsync     = pol_vsync ? vs_act : ~vs_act;
  assign de        = pol_de    ? de_act : ~de_act;
  assign pix_valid = de_act;
  assign pos_x     = x_q;
  assign pos_y     = y_q;

  p_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pos_x == $past(h_total) && pos_y == $past(v_total)));

  p_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (!pix_valid && hsync != pol_hsync && vsync != pol_vsync && de != pol_de));

  p_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!enable) && enable) |=> (pos_x == '0 && pos_y == '0));

  p_xstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(pos_x) < $past(h_total))
      |-> (pos_x == $past(pos_x) + 1'b1));

  p_yhold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && pos_x != '0) |-> $stable(pos_y));

endmodule

// File: tb/test_disp_raster_gen.sv
module test_disp_raster_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, enable, pol_hs, pol_vs, pol_de;
  logic [11:0] hse, hbe, hae, hto;
  logic [10:0] vse, vbe, vae, vto;
  logic hsync, vsync, de, pix_valid;
  logic [11:0] pos_x;
  logic [10:0] pos_y;

  int errors = 0, checks = 0;
  bit done = 0;

  disp_raster_gen i_disp_raster_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .h_sync_end(hse), .h_bp_end(hbe), .h_act_end(hae), .h_total(hto),
    .v_sync_end(vse), .v_bp_end(vbe), .v_act_end(vae), .v_total(vto),
    .pol_hsync(pol_hs), .pol_vsync(pol_vs), .pol_de(pol_de),
    .hsync(hsync), .vsync(vsync), .de(de),
    .pos_x(pos_x), .pos_y(pos_y), .pix_valid(pix_valid));

  // expected state, derived from the requirements
  int ex, ey;
  bit erun;
  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      ex <= int'(hto); ey <= int'(vto); erun <= 1'b0;
    end else begin
      erun <= 1'b1;
      if (ex >= int'(hto)) begin
        ex <= 0;
        ey <= (ey >= int'(vto)) ? 0 : ey + 1;
      end else ex <= ex + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    bit h, v, d;
    h = erun && ex <= int'(hse);
    v = erun && ey <= int'(vse);
    d = erun && ex > int'(hbe) && ex <= int'(hae) && ey > int'(vbe) && ey <= int'(vae);
    chk("R1/R4 pos_x", int'(pos_x), ex);
    chk("R1/R4 pos_y", int'(pos_y), ey);
    chk("R5/R8 hsync", int'(hsync), int'(pol_hs ? h : !h));
    chk("R6/R8 vsync", int'(vsync), int'(pol_vs ? v : !v));
    chk("R7/R8 de", int'(de), int'(pol_de ? d : !d));
    chk("R9 pix_valid", int'(pix_valid), int'(d));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_all();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0;
    pol_hs = 1'b1; pol_vs = 1'b1; pol_de = 1'b1;
    hse = 12'h009; hbe = 12'h01D; hae = 12'h15D; hto = 12'h167;
    vse = 11'h001; vbe = 11'h003; vae = 11'h0F3; vto = 11'h0F7;
    repeat (3) @(negedge clk);
    chk("R1 reset x", int'(pos_x), 359);
    chk("R1 reset y", int'(pos_y), 247);
    chk("R2 reset hsync", int'(hsync), 0);
    chk("R2 reset de", int'(de), 0);
    chk("R2 reset pix_valid", int'(pix_valid), 0);
    rst_n = 1'b1;
    cycles(4);
  endtask

  task automatic t_example();
    int de_cnt, first_de;
    de_cnt = 0; first_de = -1;
    enable = 1'b1;
    @(negedge clk);
    chk_all();
    chk("R3 origin x", int'(pos_x), 0);
    chk("R3 origin y", int'(pos_y), 0);
    chk("R3 hsync at origin", int'(hsync), 1);
    chk("R3 vsync at origin", int'(vsync), 1);
    for (int k = 1; k < 2 * 360 * 248; k++) begin
      @(negedge clk);
      chk_all();
      if (k < 360 * 248 && pix_valid) begin
        de_cnt++;
        if (first_de < 0) first_de = k;
      end
      if (k == 9)  chk("R5 hsync last", int'(hsync), 1);
      if (k == 10) chk("R5 hsync off", int'(hsync), 0);
      if (k == 360 * 248) begin
        chk("R4 frame wrap x", int'(pos_x), 0);
        chk("R4 frame wrap y", int'(pos_y), 0);
      end
    end
    chk("R7 first DE clock", first_de, 4 * 360 + 30);
    chk("R7 DE clocks per frame", de_cnt, 76800);
  endtask

  task automatic t_polarity();
    enable = 1'b0;
    @(negedge clk);
    hse = 12'd1; hbe = 12'd2; hae = 12'd6; hto = 12'd8;
    vse = 11'd0; vbe = 11'd1; vae = 11'd3; vto = 11'd4;
    pol_hs = 1'b0; pol_vs = 1'b0; pol_de = 1'b0;
    cycles(2);
    chk("R8 parked hsync high", int'(hsync), 1);
    chk("R8 parked de high", int'(de), 1);
    enable = 1'b1;
    cycles(2 * 45 + 7);
  endtask

  task automatic t_disable();
    pol_hs = 1'b1; pol_vs = 1'b0; pol_de = 1'b1;
    cycles(23);
    enable = 1'b0;
    @(negedge clk);
    chk_all();
    chk("R10 park x", int'(pos_x), 8);
    chk("R10 park y", int'(pos_y), 4);
    chk("R2 blank pix_valid", int'(pix_valid), 0);
    cycles(3);
    enable = 1'b1;
    @(negedge clk);
    chk_all();
    chk("R10 restart x", int'(pos_x), 0);
    chk("R10 restart y", int'(pos_y), 0);
    cycles(50);
  endtask

  initial begin
    t_reset();
    t_example();
    t_polarity();
    t_disable();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule